// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one SDRAM read or write burst, one address per clock. A start strobe captures the starting column, the burst-length code and the ordering bit from the mode-register image. From the next cycle onward the block emits the column sequence with a valid flag. A last flag marks the final beat.

Fixed bursts of 1, 2, 4 or 8 stay inside the aligned block that holds the start column. They wrap in either linear or interleaved order. A full-page burst walks all columns linearly and keeps going until it is terminated or restarted. A terminate input ends any burst early. A mode code that is reserved or illegal raises an error flag, and no addresses are produced for that request.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `mode_err_o` are 0.
- R2: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. `valid_o` is high for exactly that many cycles, and `last_o` is high only on the final beat.
- R3: With `burst_type_i`=0 (linear), beat n carries the start column with its low log2(len) bits replaced by (start+n) mod len. The upper bits stay unchanged.
- R4: With `burst_type_i`=1 (interleaved), beat n carries the start column with its low log2(len) bits XORed with n.
- R5: Length code 3'b111 with linear order is a full page. All 9 column bits increment each beat and wrap from 511 to 0, and `last_o` never rises.
- R6: Length codes 3'b100, 3'b101 and 3'b110 are reserved. A start with one of them sets `mode_err_o` and produces no valid beat.
- R7: A start with code 3'b111 and interleaved order sets `mode_err_o` and produces no valid beat.
- R8: `term_i` sampled high without a start makes `valid_o` low from the next cycle.
- R9: A start during an active burst drops the old burst. The next cycle shows beat 0 of the new burst.
- R10: The first beat appears the cycle after the start is sampled and carries the start column. A legal start clears `mode_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the inputs below |
| start_col_i | input | 9 | Starting column |
| bl_code_i | input | 3 | Burst-length code |
| burst_type_i | input | 1 | 0 linear, 1 interleaved |
| term_i | input | 1 | End the current burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | Current beat is the final one |
| mode_err_o | output | 1 | Last start carried an illegal mode |

## Verification
The case hardest to reach from the ports is a full-page burst that crosses the top column and wraps to zero. The stimulus starts a full page two columns below the top, so the wrap arrives within a few beats. A second hard case is a restart that lands in the middle of an 8-beat burst. The stimulus issues the second start two beats in, with a different order and alignment, and checks that the next beat already belongs to the new burst. The stimulus also covers reserved codes, and it checks that `mode_err_o` clears when a legal start follows.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef enum logic [2:0] {
    BL_ONE  = 3'b000,
    BL_TWO  = 3'b001,
    BL_FOUR = 3'b010,
    BL_EIGHT= 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;
endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       bl_code_i,
  input  logic             burst_type_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             err_o
);
  always_comb begin
    mask_o = '0;
    page_o = 1'b0;
    err_o  = 1'b0;
    case (bl_code_i)
      BL_ONE:   mask_o = COL_W'(0);
      BL_TWO:   mask_o = COL_W'(1);
      BL_FOUR:  mask_o = COL_W'(3);
      BL_EIGHT: mask_o = COL_W'(7);
      BL_PAGE: begin
        mask_o = '1;
        page_o = 1'b1;
        err_o  = burst_type_i;  // page needs linear order
      end
      default:  err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + cnt_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = !mask_i[i] ? base_i[i] :
                      ilv_i      ? (base_i[i] ^ cnt_i[i]) : sum[i];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             burst_type_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             mode_err_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page, dec_err;

  logic             active_q, err_q, ilv_q, page_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic             at_end;

  colgen_mode_dec #(.COL_W(COL_W)) u_dec (
    .bl_code_i   (bl_code_i),
    .burst_type_i(burst_type_i),
    .mask_o      (dec_mask),
    .page_o      (dec_page),
    .err_o       (dec_err)
  );

  colgen_addr_calc #(.COL_W(COL_W)) u_calc (
    .base_i(base_q),
    .cnt_i (cnt_q),
    .mask_i(mask_q),
    .ilv_i (ilv_q),
    .col_o (col_o)
  );

  assign at_end = !page_q && (cnt_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
      ilv_q    <= 1'b0;
      page_q   <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= !dec_err;
      err_q    <= dec_err;
      ilv_q    <= burst_type_i;
      page_q   <= dec_page;
      base_q   <= start_col_i;
      cnt_q    <= '0;
      mask_q   <= dec_mask;
    end else if (term_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (at_end) active_q <= 1'b0;
      else        cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign valid_o    = active_q;
  assign last_o     = active_q && at_end;
  assign mode_err_o = err_q;
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             mode_err_o
);
  p_last_in_burst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_stop_after_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  p_err_no_beat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> !valid_o);

  p_term_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !start_i) |=> !valid_o);

  p_first_beat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (mode_err_o || (valid_o && col_o == $past(start_col_i))));
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       burst_type_i = 1'b0;
  logic       term_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o, mode_err_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  sdram_burst_colgen u_dut (.*);

  // {type, code, column}
  localparam logic [12:0] VECS [10] = '{
    {1'b0, 3'b000, 9'h0A5}, {1'b0, 3'b001, 9'h0A5},
    {1'b0, 3'b010, 9'h1E6}, {1'b1, 3'b010, 9'h1E6},
    {1'b0, 3'b011, 9'h1FD}, {1'b1, 3'b011, 9'h1FD},
    {1'b1, 3'b000, 9'h033}, {1'b1, 3'b001, 9'h033},
    {1'b0, 3'b011, 9'h100}, {1'b1, 3'b011, 9'h0F0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [2:0] code);
    return 1 << code;
  endfunction

  function automatic logic [8:0] exp_col(input logic [8:0] s, input logic [2:0] code,
                                         input logic bt, input int n);
    logic [8:0] m, lo;
    m  = 9'(blen(code) - 1);
    lo = bt ? (s ^ 9'(n)) : (s + 9'(n));
    return (s & ~m) | (lo & m);
  endfunction

  task automatic launch(input logic [8:0] c, input logic [2:0] code, input logic bt);
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = c; bl_code_i = code; burst_type_i = bt;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk(valid_o == 0, "R1 valid", valid_o, 0);
    chk(last_o == 0, "R1 last", last_o, 0);
    chk(mode_err_o == 0, "R1 err", mode_err_o, 0);
    rst_ni = 1'b1;

    // table walk: R2 lengths, R3 linear, R4 interleaved
    foreach (VECS[v]) begin
      automatic logic [8:0] c = VECS[v][8:0];
      automatic logic [2:0] code = VECS[v][11:9];
      automatic logic bt = VECS[v][12];
      automatic int len = blen(code);
      launch(c, code, bt);
      for (int n = 0; n < len; n++) begin
        chk(valid_o == 1, "R2 valid", valid_o, 1);
        chk(last_o == (n == len - 1), "R2 last", last_o, int'(n == len - 1));
        chk(col_o == exp_col(c, code, bt, n), bt ? "R4 col" : "R3 col",
            col_o, exp_col(c, code, bt, n));
        @(negedge clk_i);
      end
      chk(valid_o == 0, "R2 end", valid_o, 0);
    end

    // R5 full page with wrap, then R8 terminate
    launch(9'h1FE, 3'b111, 1'b0);
    chk(col_o == 9'h1FE, "R10 first", col_o, 9'h1FE);
    for (int n = 0; n < 6; n++) begin
      automatic logic [8:0] e = 9'h1FE + 9'(n);
      chk(valid_o && !last_o, "R5 run", {valid_o, last_o}, 2'b10);
      chk(col_o == e, "R5 col", col_o, e);
      @(negedge clk_i);
    end
    term_i = 1'b1;
    @(negedge clk_i);
    term_i = 1'b0;
    chk(valid_o == 0, "R8 term", valid_o, 0);

    // R6 reserved codes
    for (int k = 4; k < 7; k++) begin
      launch(9'h010, 3'(k), 1'b0);
      chk(mode_err_o == 1, "R6 err", mode_err_o, 1);
      chk(valid_o == 0, "R6 no beat", valid_o, 0);
    end
    // R7 page with interleaved order
    launch(9'h010, 3'b111, 1'b1);
    chk(mode_err_o == 1, "R7 err", mode_err_o, 1);
    chk(valid_o == 0, "R7 no beat", valid_o, 0);
    // R10 legal start clears error
    launch(9'h055, 3'b001, 1'b0);
    chk(mode_err_o == 0, "R10 err clear", mode_err_o, 1'b0);
    chk(valid_o && col_o == 9'h055, "R10 beat", col_o, 9'h055);

    // R9 restart mid burst
    launch(9'h010, 3'b011, 1'b0);
    @(negedge clk_i);
    chk(col_o == 9'h011, "R9 old", col_o, 9'h011);
    start_i = 1'b1; start_col_i = 9'h043; bl_code_i = 3'b010; burst_type_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int n = 0; n < 4; n++) begin
      automatic logic [8:0] e = 9'h043 ^ 9'(n);
      chk(valid_o && col_o == e, "R9 new", col_o, e);
      chk(last_o == (n == 3), "R9 last", last_o, int'(n == 3));
      @(negedge clk_i);
    end
    chk(valid_o == 0, "R9 end", valid_o, 0);

    // R8 terminate a fixed burst early
    launch(9'h020, 3'b011, 1'b0);
    term_i = 1'b1;
    @(negedge clk_i);
    term_i = 1'b0;
    chk(valid_o == 0, "R8 early", valid_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule